// File: doc/BRIEF.md
# Two-Field Aggregated Bit-Vector Rule Classifier

This block chooses the winning rule for a packet from two header fields. An external per-field prefix lookup supplies one rule vector for each field. Bit j of a field's vector is set when the longest prefix matched in that field, or any shorter prefix of it, satisfies rule j in that field. The rules that the packet satisfies are the bitwise intersection of the two vectors. The winner is the lowest-numbered rule in that intersection.

The full intersection is not formed in one step. The block first reduces each vector to a short summary vector, in which each bit stands for one group of A consecutive rule bits. Only groups whose two summary bits are both set are examined, one group per clock, from the lowest group upward. A group can pass the summary test and still have an empty full intersection. This is a false positive, and the scan then moves on to the next candidate group. The request enters on a valid/ready pair. The result appears as a one-cycle valid pulse carrying either a rule index or a no-match flag.

Top module: `abv_classifier`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Summary bit g of a field is the OR of rule bits g*A through g*A+A-1 of that field. The last group is cut short when N is not a multiple of A.
- R3: A group is a candidate only when both fields' summary bits for it are 1. Non-candidate groups take no scan cycle.
- R4: A candidate group whose full two-field AND is zero is a false positive. The scan continues with the next higher candidate in the following cycle.
- R5: On a hit, `out_miss` is 0 and `out_rule` is the lowest bit position set in `in_vec_a & in_vec_b`. Rule 0 has the highest priority.
- R6: When no candidate yields a set bit, `out_miss` is 1 and `out_rule` is 0.
- R7: A request is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the edge after the result pulse, and `in_valid` has no effect during that time.
- R8: `out_valid` is high for exactly one cycle per accepted request. `out_rule` is ceil(log2 N) bits wide.
- R9: Latency is counted in clock edges after the accepting edge. A hit found at the j-th candidate group raises `out_valid` after j edges. A miss with c candidates raises it after c+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_vec_a | input | N | Rule vector for the first field |
| in_vec_b | input | N | Rule vector for the second field |
| out_valid | output | 1 | One-cycle result strobe |
| out_miss | output | 1 | No rule matched both fields |
| out_rule | output | ceil(log2 N) | Winning rule index, 0 on a miss |

## Verification
The bench builds the block with N = 16 and A = 4, which gives four groups.

Four groups are enough to cover several cases:
- a hit in the first or the last group;
- a single candidate reached by skipping lower groups;
- chains of one to three false positives before a hit;
- a miss in which every group is a false positive, which gives the longest latency of five edges.

Measuring latency in edges shows which groups the scan visited and which it skipped. That exposes both the summary reduction and the candidate selection at the ports.

// File: rtl/abv_pkg.sv
package abv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } abv_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/abv_aggregate.sv
module abv_aggregate #(
  parameter int N = 16,
  parameter int A = 4,
  parameter int K = 4
) (
  input  logic [N-1:0] vec,
  output logic [K-1:0] agg
);
  for (genvar g = 0; g < K; g++) begin : g_grp
    localparam int LO = g * A;
    localparam int HI = ((LO + A) < N) ? (LO + A - 1) : (N - 1);
    assign agg[g] = |vec[HI:LO];
  end
endmodule

// File: rtl/abv_lowest.sv
module abv_lowest #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  v,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) idx = IW'(i);
    end
  end
  assign any = |v;
endmodule

// File: rtl/abv_classifier.sv
module abv_classifier
  import abv_pkg::*;
#(
  parameter int N = 16,
  parameter int A = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N-1:0]              in_vec_a,
  input  logic [N-1:0]              in_vec_b,
  output logic                      out_valid,
  output logic                      out_miss,
  output logic [idx_width(N)-1:0]   out_rule
);
  localparam int K  = ceil_div(N, A);
  localparam int IW = idx_width(N);
  localparam int KW = idx_width(K);
  localparam int AW = idx_width(A);
  localparam int PW = K * A;

  abv_state_e       state;
  logic [N-1:0]     vec_a_q, vec_b_q;
  logic [K-1:0]     cand_q;
  logic [IW-1:0]    res_rule;
  logic             res_miss;

  logic [K-1:0]     agg_a, agg_b;
  logic [KW-1:0]    cur_blk;
  logic             cand_any;
  logic [PW-1:0]    and_pad;
  logic [A-1:0]     blk_bits;
  logic [AW-1:0]    blk_off;
  logic             blk_any;

  // Observation wires for the checker.
  logic             accept, scan_active, cand_empty, blk_hit;

  function automatic logic [IW-1:0] rule_of(input logic [KW-1:0] g,
                                            input logic [AW-1:0] off);
    return IW'(int'(g) * A + int'(off));
  endfunction

  abv_aggregate #(.N(N), .A(A), .K(K)) u_agg_a (.vec(in_vec_a), .agg(agg_a));
  abv_aggregate #(.N(N), .A(A), .K(K)) u_agg_b (.vec(in_vec_b), .agg(agg_b));

  abv_lowest #(.W(K), .IW(KW)) u_pick_blk (.v(cand_q), .idx(cur_blk), .any(cand_any));

  assign and_pad  = PW'(vec_a_q & vec_b_q);
  assign blk_bits = and_pad[int'(cur_blk) * A +: A];

  abv_lowest #(.W(A), .IW(AW)) u_pick_bit (.v(blk_bits), .idx(blk_off), .any(blk_any));

  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = (state == ST_DONE);
  assign out_miss    = res_miss;
  assign out_rule    = res_rule;
  assign accept      = in_valid & in_ready;
  assign scan_active = (state == ST_SCAN);
  assign cand_empty  = ~cand_any;
  assign blk_hit     = blk_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      vec_a_q  <= '0;
      vec_b_q  <= '0;
      cand_q   <= '0;
      res_rule <= '0;
      res_miss <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            vec_a_q <= in_vec_a;
            vec_b_q <= in_vec_b;
            cand_q  <= agg_a & agg_b;
            state   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!cand_any) begin
            res_miss <= 1'b1;
            res_rule <= '0;
            state    <= ST_DONE;
          end else if (blk_any) begin
            res_miss <= 1'b0;
            res_rule <= rule_of(cur_blk, blk_off);
            state    <= ST_DONE;
          end else begin
            cand_q <= cand_q & ~(K'(1) << cur_blk);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abv_classifier_chk.sv
module abv_classifier_chk #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_miss,
  input logic [IW-1:0] out_rule,
  input logic [N-1:0]  vec_a_q,
  input logic [N-1:0]  vec_b_q,
  input logic          scan_active,
  input logic          cand_empty,
  input logic          blk_hit
);
  logic [N-1:0] and_v, low_mask;
  assign and_v    = vec_a_q & vec_b_q;
  assign low_mask = (N'(1) << out_rule) - N'(1);

  p_busy_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_no_ready_on_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_fp_keeps_scanning_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active && !cand_empty && !blk_hit) |=> scan_active);
  p_exhausted_misses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active && cand_empty) |=> (out_valid && out_miss));
  p_miss_index_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_rule == '0 && and_v == '0));
  p_hit_in_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> and_v[out_rule]);
  p_hit_is_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> ((and_v & low_mask) == '0));
endmodule

bind abv_classifier abv_classifier_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_miss(out_miss), .out_rule(out_rule),
  .vec_a_q(vec_a_q), .vec_b_q(vec_b_q), .scan_active(scan_active),
  .cand_empty(cand_empty), .blk_hit(blk_hit)
);

// File: tb/sim_abv_classifier.sv
`timescale 1ns/1ps
module sim_abv_classifier;
  localparam int N = 16;
  localparam int A = 4;
  localparam int K = (N + A - 1) / A;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [N-1:0] in_vec_a = '0, in_vec_b = '0;
  logic in_ready, out_valid, out_miss;
  logic [3:0] out_rule;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  abv_classifier #(.N(N), .A(A)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec_a(in_vec_a), .in_vec_b(in_vec_b), .out_valid(out_valid),
    .out_miss(out_miss), .out_rule(out_rule));

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic predict(input logic [N-1:0] a, input logic [N-1:0] b,
                         output int rule, output int miss, output int lat);
    logic [N-1:0] both = a & b;
    rule = 0; miss = 1; lat = 0;
    for (int g = 0; g < K; g++) begin
      bit sa = 0, sb = 0, any = 0;
      for (int i = g * A; i < g * A + A && i < N; i++) begin
        sa |= a[i]; sb |= b[i];
      end
      if (sa && sb) begin
        lat++;
        for (int i = g * A + A - 1; i >= g * A; i--)
          if (i < N && both[i]) begin rule = i; any = 1; end
        if (any) begin miss = 0; return; end
      end
    end
    lat++;
    rule = 0;
  endtask

  task automatic run_req(input logic [N-1:0] a, input logic [N-1:0] b,
                         input string tag, input bit busy_noise);
    int er, em, el, lat;
    predict(a, b, er, em, el);
    @(negedge clk);
    check("R7", in_ready, 1, {tag, " ready before request"});
    in_valid = 1; in_vec_a = a; in_vec_b = b;
    @(posedge clk);
    lat = 0;
    while (1) begin
      @(negedge clk);
      if (busy_noise) begin
        in_valid = 1; in_vec_a = ~a; in_vec_b = ~b;
      end else in_valid = 0;
      if (out_valid) break;
      if (lat > 0 || busy_noise) check("R7", in_ready, 0, {tag, " ready while busy"});
      @(posedge clk);
      lat++;
      if (lat > 40) break;
    end
    in_valid = 0;
    check("R9", lat, el, {tag, " latency"});
    check("R6", out_miss, em, {tag, " miss flag"});
    check("R5", out_rule, er, {tag, " rule index"});
    @(negedge clk);
    check("R8", out_valid, 0, {tag, " pulse width"});
    check("R7", in_ready, 1, {tag, " ready after result"});
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", out_valid, 0, "out_valid in reset");
    check("R1", in_ready, 1, "in_ready in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", out_valid, 0, "out_valid after reset");
    check("R1", in_ready, 1, "in_ready after reset");
  endtask

  task automatic t_first_group_hit();   // R5 R9
    run_req(16'h0001, 16'h0001, "first group", 0);
  endtask
  task automatic t_false_positive();    // R4: group 0 fp, group 1 hits rule 5
    run_req(16'h002E, 16'h0061, "false positive", 0);
  endtask
  task automatic t_no_candidate();      // R3 R6
    run_req(16'h000F, 16'hF000, "no candidate", 0);
    run_req(16'h0000, 16'h0000, "empty vectors", 0);
  endtask
  task automatic t_all_fp_miss();       // R4 R6: four fps, five edges
    run_req(16'h5555, 16'hAAAA, "all fp", 0);
  endtask
  task automatic t_last_rule();         // R5 boundary
    run_req(16'h8000, 16'h8000, "last rule", 0);
    run_req(16'h8111, 16'h8222, "three fp then rule 15", 0);
  endtask
  task automatic t_skip_groups();       // R2 R3: only group 3 is a candidate
    run_req(16'hF0F0, 16'hF00F, "skip to group 3", 0);
    run_req(16'h0C00, 16'h0E00, "priority in group", 0);
  endtask
  task automatic t_busy_ignore();       // R7: noise on in_valid while busy
    run_req(16'h0240, 16'h0620, "busy noise", 1);
  endtask
  task automatic t_patterns();
    logic [31:0] s = 32'h1234_5678;
    for (int n = 0; n < 12; n++) begin
      logic [N-1:0] a, b;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      a = s[15:0] & s[31:16];
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      b = s[15:0] & s[31:16];
      run_req(a, b, $sformatf("pattern %0d", n), 0);
    end
  endtask

  initial begin
    t_reset();
    t_first_group_hit();
    t_false_positive();
    t_no_candidate();
    t_all_fp_miss();
    t_last_rule();
    t_skip_groups();
    t_busy_ignore();
    t_patterns();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule